// File: doc/BRIEF.md
# Descriptor-Based Request Port Router

This block sits at the entry of an eight-port interconnect hub. It decides which output port each incoming request leaves on. Memory and I/O requests are matched against small banks of programmable address descriptors, with one bank for each space. Each descriptor holds a base, a mask, an enable bit and a destination port. A request that matches no enabled descriptor leaves on a fixed default port.

Configuration requests are not matched against descriptors. They carry a path of 3-bit hop numbers in the upper address bits. The hub takes the leading hop as the output port and shifts the path so that the next hub finds its own hop at the top. A leading hop of zero means the access is for the hub itself, and the request is passed to port 0 unchanged.

The block has one registered pipeline stage. An accepted request shows up on the output side in the next cycle together with its selected port. Input ready is withheld while the output holds a request that has not been taken. Descriptors are programmed through a simple write port that loads one whole descriptor per cycle.

Top module: `req_router`

## Requirements
- R1: After a synchronous active-low reset, out_valid is 0 and every descriptor in both banks is disabled, so memory and I/O requests leave on port 4.
- R2: A request is accepted when in_valid and in_ready are both 1. It appears on the outputs with out_valid = 1 on the next clock edge. While out_valid = 1 and out_ready = 0, in_ready is 0 and all outputs hold steady. in_ready is 1 whenever out_valid = 0 or out_ready = 1.
- R3: A memory request (in_space = 0) whose address satisfies (addr & mask) == (base & mask) for an enabled memory descriptor leaves on that descriptor's port. Its address, byte enables and space are forwarded unchanged.
- R4: When several enabled descriptors of one bank match, the descriptor with the lowest index selects the port.
- R5: A memory or I/O request that matches no enabled descriptor of its bank leaves on port 4. A disabled descriptor never matches.
- R6: Memory descriptors affect only memory requests, and I/O descriptors affect only I/O requests (in_space = 1).
- R7: I/O matching uses only address bits 19:0 of the request, base and mask. The forwarded I/O address has bits 31:20 cleared and bits 19:0 unchanged. Byte enables are forwarded unchanged.
- R8: For a configuration request (in_space = 2), the hop field is address bits 31:29 and the path field is bits 31:14. When the hop is nonzero, the request leaves on port = hop. The path field is shifted left by 3 with zeros entering bits 16:14, and bits 13:0 are forwarded unchanged.
- R9: A configuration request with hop 0 leaves on port 0 with its address unchanged.
- R10: A request with in_space = 3 leaves on port 4 with its address unchanged.
- R11: A write with cfg_we = 1 loads the descriptor selected by cfg_io (0 = memory bank, 1 = I/O bank) and cfg_idx with cfg_en, cfg_base, cfg_mask and cfg_port. The new descriptor governs requests accepted from the following cycle onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Router can accept a request |
| in_space | input | 2 | 0 memory, 1 I/O, 2 configuration, 3 reserved |
| in_addr | input | 32 | Request byte address or configuration path |
| in_be | input | 4 | Request byte enables |
| out_valid | output | 1 | Routed request present |
| out_ready | input | 1 | Downstream takes the routed request |
| out_port | output | 3 | Selected output port |
| out_space | output | 2 | Forwarded space code |
| out_addr | output | 32 | Forwarded (possibly rewritten) address |
| out_be | output | 4 | Forwarded byte enables |
| cfg_we | input | 1 | Descriptor write strobe |
| cfg_io | input | 1 | Bank select: 0 memory, 1 I/O |
| cfg_idx | input | 2 | Descriptor index within the bank |
| cfg_en | input | 1 | Enable bit to load |
| cfg_base | input | 32 | Base to load |
| cfg_mask | input | 32 | Mask to load |
| cfg_port | input | 3 | Destination port to load |

## Verification
The bench builds the router with its default parameters: eight ports, four descriptors per bank, a 20-bit I/O compare width and a six-hop path. Because the configuration is this small, the bench can sweep every hop value, and it can cover each descriptor's region with overlapping, disabled and re-enabled entries. The sweeps also include I/O addresses carrying garbage in the upper twelve bits. Expected ports and rewritten addresses come from shift-and-mask arithmetic over the bench's own copy of the programmed descriptors. A stall sequence checks that outputs hold and that ready is withheld.

// File: rtl/router_pkg.sv
// Package: shared space codes for the request router.
// Assumes a 2-bit space field on the request.
package router_pkg;
    typedef enum logic [1:0] {
        SP_MEM = 2'd0,
        SP_IO  = 2'd1,
        SP_CFG = 2'd2,
        SP_RSV = 2'd3
    } space_e;
endpackage

// File: rtl/desc_bank.sv
// desc_bank: a bank of N base/mask/enable/port descriptors with a
// lowest-index-wins address match.
// Assumes writes load a whole descriptor; an index at or above N is dropped.
module desc_bank #(
    parameter int N     = 4,
    parameter int AW    = 32,
    parameter int PW    = 3,
    parameter int IDX_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic             wr_enable,
    input  logic [AW-1:0]    wr_base,
    input  logic [AW-1:0]    wr_mask,
    input  logic [PW-1:0]    wr_port,
    input  logic [AW-1:0]    lk_addr,
    output logic             hit,
    output logic [PW-1:0]    hit_port
);
    logic [AW-1:0] base_q [N];
    logic [AW-1:0] mask_q [N];
    logic [PW-1:0] port_q [N];
    logic [N-1:0]  en_q;
    logic [N-1:0]  match;

    // Load the addressed descriptor; reset clears every enable.
    always_ff @(posedge clk) begin
        for (int k = 0; k < N; k++) begin
            if (!rst_n) begin
                en_q[k]   <= 1'b0;
                base_q[k] <= '0;
                mask_q[k] <= '0;
                port_q[k] <= '0;
            end else if (wr_en && wr_idx == IDX_W'(k)) begin
                en_q[k]   <= wr_enable;
                base_q[k] <= wr_base;
                mask_q[k] <= wr_mask;
                port_q[k] <= wr_port;
            end
        end
    end

    // One comparator for each descriptor.
    for (genvar g = 0; g < N; g++) begin : g_cmp
        // Masked equality for descriptor g.
        always_comb match[g] = en_q[g] && ((lk_addr & mask_q[g]) == (base_q[g] & mask_q[g]));
    end

    // Priority pick: the lowest matching index wins.
    always_comb begin
        hit      = 1'b0;
        hit_port = '0;
        for (int k = N - 1; k >= 0; k--) begin
            if (match[k]) begin
                hit      = 1'b1;
                hit_port = port_q[k];
            end
        end
    end
endmodule

// File: rtl/cfg_hop.sv
// cfg_hop: takes the leading hop from a configuration path and shifts the
// path by one hop.
// Assumes the path occupies the top HOPS*PW address bits and the register
// select occupies the rest.
module cfg_hop #(
    parameter int AW   = 32,
    parameter int PW   = 3,
    parameter int HOPS = 6
) (
    input  logic [AW-1:0] addr,
    output logic [PW-1:0] hop,
    output logic [AW-1:0] fwd_addr
);
    localparam int PATH_W = HOPS * PW;
    localparam int REG_W  = AW - PATH_W;

    // Leading hop and the rewritten address (unchanged when the hub is the target).
    always_comb begin
        hop = addr[AW-1 -: PW];
        if (hop == '0)
            fwd_addr = addr;
        else
            fwd_addr = {addr[AW-PW-1:REG_W], {PW{1'b0}}, addr[REG_W-1:0]};
    end
endmodule

// File: rtl/out_stage.sv
// out_stage: a single registered valid/ready stage.
// Assumes the upstream holds its data while ready is low.
module out_stage #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    output logic          in_ready,
    input  logic [DW-1:0] in_data,
    output logic          out_valid,
    input  logic          out_ready,
    output logic [DW-1:0] out_data
);
    // Accept when empty or when the held entry leaves this cycle.
    always_comb in_ready = !out_valid || out_ready;

    // Capture an accepted entry; drop the held entry once it is taken.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else if (in_ready) begin
            out_valid <= in_valid;
            if (in_valid)
                out_data <= in_data;
        end
    end
endmodule

// File: rtl/req_router.sv
// req_router: picks the output port for each request on an eight-port hub.
// Memory and I/O requests use descriptor banks, configuration requests use
// hop paths, and misses go to a fixed default port.
// Assumes port 0 is the hub itself; one registered output stage.
module req_router #(
    parameter int NUM_PORTS    = 8,
    parameter int PW           = $clog2(NUM_PORTS),
    parameter int AW           = 32,
    parameter int IO_W         = 20,
    parameter int BE_W         = 4,
    parameter int MEM_DESCS    = 4,
    parameter int IO_DESCS     = 4,
    parameter int IDX_W        = $clog2((MEM_DESCS > IO_DESCS) ? MEM_DESCS : IO_DESCS),
    parameter int HOPS         = 6,
    parameter int DEFAULT_PORT = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [1:0]       in_space,
    input  logic [AW-1:0]    in_addr,
    input  logic [BE_W-1:0]  in_be,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [PW-1:0]    out_port,
    output logic [1:0]       out_space,
    output logic [AW-1:0]    out_addr,
    output logic [BE_W-1:0]  out_be,
    input  logic             cfg_we,
    input  logic             cfg_io,
    input  logic [IDX_W-1:0] cfg_idx,
    input  logic             cfg_en,
    input  logic [AW-1:0]    cfg_base,
    input  logic [AW-1:0]    cfg_mask,
    input  logic [PW-1:0]    cfg_port
);
    import router_pkg::*;

    localparam int DW = PW + 2 + AW + BE_W;
    localparam logic [PW-1:0] DEF_P = PW'(DEFAULT_PORT);

    logic            mem_hit, io_hit;
    logic [PW-1:0]   mem_port, io_port, hop;
    logic [AW-1:0]   cfg_addr;
    logic [PW-1:0]   sel_port;
    logic [AW-1:0]   sel_addr;
    logic [DW-1:0]   stage_in, stage_out;

    desc_bank #(.N(MEM_DESCS), .AW(AW), .PW(PW), .IDX_W(IDX_W)) u_mem (
        .clk(clk), .rst_n(rst_n),
        .wr_en(cfg_we && !cfg_io), .wr_idx(cfg_idx), .wr_enable(cfg_en),
        .wr_base(cfg_base), .wr_mask(cfg_mask), .wr_port(cfg_port),
        .lk_addr(in_addr), .hit(mem_hit), .hit_port(mem_port)
    );

    desc_bank #(.N(IO_DESCS), .AW(IO_W), .PW(PW), .IDX_W(IDX_W)) u_io (
        .clk(clk), .rst_n(rst_n),
        .wr_en(cfg_we && cfg_io), .wr_idx(cfg_idx), .wr_enable(cfg_en),
        .wr_base(cfg_base[IO_W-1:0]), .wr_mask(cfg_mask[IO_W-1:0]), .wr_port(cfg_port),
        .lk_addr(in_addr[IO_W-1:0]), .hit(io_hit), .hit_port(io_port)
    );

    cfg_hop #(.AW(AW), .PW(PW), .HOPS(HOPS)) u_hop (
        .addr(in_addr), .hop(hop), .fwd_addr(cfg_addr)
    );

    // Choose the port and the forwarded address by space.
    always_comb begin
        unique case (space_e'(in_space))
            SP_MEM: begin
                sel_port = mem_hit ? mem_port : DEF_P;
                sel_addr = in_addr;
            end
            SP_IO: begin
                sel_port = io_hit ? io_port : DEF_P;
                sel_addr = {{(AW-IO_W){1'b0}}, in_addr[IO_W-1:0]};
            end
            SP_CFG: begin
                sel_port = hop;
                sel_addr = cfg_addr;
            end
            default: begin
                sel_port = DEF_P;
                sel_addr = in_addr;
            end
        endcase
    end

    // Pack the routed request for the output register.
    always_comb stage_in = {sel_port, in_space, sel_addr, in_be};

    out_stage #(.DW(DW)) u_out (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(stage_in),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(stage_out)
    );

    // Unpack the registered request onto the output ports.
    always_comb {out_port, out_space, out_addr, out_be} = stage_out;
endmodule

// File: rtl/req_router_chk.sv
// req_router_chk: temporal checks on the router ports, bound into every instance.
module req_router_chk #(
    parameter int PW   = 3,
    parameter int AW   = 32,
    parameter int IO_W = 20,
    parameter int BE_W = 4
) (
    input logic            clk,
    input logic            rst_n,
    input logic            in_valid,
    input logic            in_ready,
    input logic [1:0]      in_space,
    input logic [AW-1:0]   in_addr,
    input logic            out_valid,
    input logic            out_ready,
    input logic [PW-1:0]   out_port,
    input logic [1:0]      out_space,
    input logic [AW-1:0]   out_addr,
    input logic [BE_W-1:0] out_be
);
    import router_pkg::*;

    // R1
    reset_idle_chk: assert property (@(posedge clk) !rst_n |=> !out_valid);

    // R2
    stall_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |-> !in_ready);

    // R2
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_port) && $stable(out_addr)
                                       && $stable(out_be) && $stable(out_space)));

    // R2
    accept_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> out_valid);

    // R7
    io_upper_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_space == SP_IO) |-> (out_addr[AW-1:IO_W] == '0));

    // R8
    cfg_hop_port_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && in_space == SP_CFG && in_addr[AW-1 -: PW] != '0)
        |=> out_port == $past(in_addr[AW-1 -: PW]));

    // R9
    cfg_self_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && in_space == SP_CFG && in_addr[AW-1 -: PW] == '0)
        |=> (out_port == '0 && out_addr == $past(in_addr)));
endmodule

bind req_router req_router_chk #(.PW(PW), .AW(AW), .IO_W(IO_W), .BE_W(BE_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_space(in_space), .in_addr(in_addr), .out_valid(out_valid),
    .out_ready(out_ready), .out_port(out_port), .out_space(out_space),
    .out_addr(out_addr), .out_be(out_be)
);

// File: tb/sim_req_router.sv
// sim_req_router: sweeps the router against an arithmetic model of the descriptors.
module sim_req_router;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0, in_ready;
    logic [1:0]  in_space = '0;
    logic [31:0] in_addr = '0;
    logic [3:0]  in_be = '0;
    logic        out_valid, out_ready = 1'b1;
    logic [2:0]  out_port;
    logic [1:0]  out_space;
    logic [31:0] out_addr;
    logic [3:0]  out_be;
    logic        cfg_we = 1'b0, cfg_io = 1'b0, cfg_en = 1'b0;
    logic [1:0]  cfg_idx = '0;
    logic [31:0] cfg_base = '0, cfg_mask = '0;
    logic [2:0]  cfg_port = '0;

    int checks = 0;
    int errors = 0;

    // Bench copy of the descriptors: index 0..3 memory, 4..7 I/O.
    logic [31:0] m_base [8];
    logic [31:0] m_mask [8];
    logic [2:0]  m_port [8];
    logic        m_en   [8];

    always #(CLK_PERIOD/2) clk = ~clk;

    req_router u0 (.*);

    task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, got, exp);
        end
    endtask

    function automatic logic [2:0] exp_port(input logic [1:0] sp, input logic [31:0] a);
        logic found = 1'b0;
        logic [2:0] p = 3'd4;
        if (sp == 2'd2) return a[31:29];
        if (sp == 2'd3) return 3'd4;
        for (int k = 0; k < 4; k++) begin
            int j = (sp == 2'd1) ? k + 4 : k;
            logic [31:0] diff = (a ^ m_base[j]) & m_mask[j];
            if (sp == 2'd1) diff = diff & 32'h000F_FFFF;
            if (!found && m_en[j] && diff == 0) begin
                found = 1'b1;
                p = m_port[j];
            end
        end
        return p;
    endfunction

    function automatic logic [31:0] exp_addr(input logic [1:0] sp, input logic [31:0] a);
        if (sp == 2'd1) return a & 32'h000F_FFFF;
        if (sp == 2'd2 && (a >> 29) != 0)
            return (((a >> 14) << 17) & 32'hFFFF_C000) | (a & 32'h0000_3FFF);
        return a;
    endfunction

    task automatic write_desc(input logic io, input int idx, input logic en,
                              input logic [31:0] b, input logic [31:0] m, input logic [2:0] p);
        @(negedge clk);
        cfg_we = 1'b1; cfg_io = io; cfg_idx = 2'(idx); cfg_en = en;
        cfg_base = b; cfg_mask = m; cfg_port = p;
        m_base[idx + (io ? 4 : 0)] = b;
        m_mask[idx + (io ? 4 : 0)] = m;
        m_port[idx + (io ? 4 : 0)] = p;
        m_en[idx + (io ? 4 : 0)]   = en;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic send(input string tag, input logic [1:0] sp, input logic [31:0] a, input logic [3:0] be);
        @(negedge clk);
        in_valid = 1'b1; in_space = sp; in_addr = a; in_be = be;
        @(negedge clk);
        in_valid = 1'b0;
        check({tag, " valid"}, 64'(out_valid), 64'd1);
        check({tag, " port"}, 64'(out_port), 64'(exp_port(sp, a)));
        check({tag, " addr"}, 64'(out_addr), 64'(exp_addr(sp, a)));
        check({tag, " be/space"}, 64'({out_be, out_space}), 64'({be, sp}));
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int k = 0; k < 8; k++) begin
            m_base[k] = '0; m_mask[k] = '0; m_port[k] = '0; m_en[k] = 1'b0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: idle after reset, empty banks route to the default port.
        check("R1 out_valid after reset", 64'(out_valid), 64'd0);
        check("R2 in_ready when idle", 64'(in_ready), 64'd1);
        send("R1 R5 mem miss empty bank", 2'd0, 32'h1234_5678, 4'hF);
        send("R1 R5 io miss empty bank", 2'd1, 32'hABC0_1000, 4'h3);

        // R11: program the memory bank; d1 overlaps d0 (R4), d2 disabled (R5).
        write_desc(1'b0, 0, 1'b1, 32'h1000_0000, 32'hF000_0000, 3'd2);
        write_desc(1'b0, 1, 1'b1, 32'h1000_0000, 32'hFF00_0000, 3'd5);
        write_desc(1'b0, 2, 1'b0, 32'h2000_0000, 32'hF000_0000, 3'd6);
        write_desc(1'b0, 3, 1'b1, 32'h3000_0000, 32'hF000_0000, 3'd0);
        for (int i = 0; i < 16; i++)
            for (int j = 0; j < 4; j++)
                send("R3 R4 R5 mem sweep", 2'd0, (32'(i) << 28) | (32'(j) << 24) | (32'(i) * 32'h1357), 4'(i));
        write_desc(1'b0, 2, 1'b1, 32'h2000_0000, 32'hF000_0000, 3'd6);
        for (int i = 0; i < 4; i++)
            send("R11 mem after enable", 2'd0, (32'(i) << 28) | 32'h0055_0000, 4'hF);
        write_desc(1'b0, 0, 1'b0, 32'h1000_0000, 32'hF000_0000, 3'd2);
        for (int j = 0; j < 4; j++)
            send("R4 R11 mem d1 after d0 off", 2'd0, 32'h1000_0000 | (32'(j) << 24) | 32'h77, 4'h1);

        // R6 R7: I/O bank with overlap; upper address bits carry garbage.
        write_desc(1'b1, 0, 1'b1, 32'hFFF0_1000, 32'h000F_F000, 3'd1);
        write_desc(1'b1, 1, 1'b1, 32'h0000_2000, 32'h000F_F000, 3'd7);
        write_desc(1'b1, 2, 1'b1, 32'h0000_1000, 32'h000F_FF00, 3'd3);
        write_desc(1'b1, 3, 1'b0, 32'h0000_3000, 32'h000F_F000, 3'd6);
        for (int i = 0; i < 16; i++)
            for (int j = 0; j < 8; j++)
                send("R6 R7 io sweep", 2'd1, (32'(j * 37) << 20) | (32'(i % 4) << 12) | (32'(i) << 4) | 32'(j), 4'(j));
        send("R6 io ignores mem bank", 2'd1, 32'h3000_0000, 4'hF);
        send("R6 mem ignores io bank", 2'd0, 32'h0000_2000, 4'hF);

        // R8 R9: every leading hop with several paths.
        for (int h = 0; h < 8; h++)
            for (int k = 0; k < 4; k++)
                send("R8 R9 cfg hop", 2'd2, (32'(h) << 29) | ((32'(k) * 32'h0123_4567) & 32'h1FFF_FFFF), 4'hF);

        // R10: reserved space code.
        send("R10 reserved space", 2'd3, 32'h1000_0000, 4'h5);
        send("R10 reserved space", 2'd3, 32'hE000_0001, 4'hA);

        // R2: stall with a second request waiting.
        @(negedge clk);
        out_ready = 1'b0; in_valid = 1'b1; in_space = 2'd0; in_addr = 32'h3000_0010; in_be = 4'h2;
        @(negedge clk);
        check("R2 stall first valid", 64'(out_valid), 64'd1);
        check("R2 stall ready low", 64'(in_ready), 64'd0);
        in_addr = 32'h2000_0020; in_be = 4'h4;
        @(negedge clk);
        check("R2 stall hold addr", 64'(out_addr), 64'h3000_0010);
        check("R2 stall hold port", 64'(out_port), 64'd0);
        check("R2 stall ready still low", 64'(in_ready), 64'd0);
        out_ready = 1'b1;
        #1;
        check("R2 ready on drain", 64'(in_ready), 64'd1);
        @(negedge clk);
        in_valid = 1'b0;
        check("R2 second addr", 64'(out_addr), 64'h2000_0020);
        check("R2 second port", 64'(out_port), 64'd6);
        @(negedge clk);
        check("R2 empty after drain", 64'(out_valid), 64'd0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule